// File: doc/BRIEF.md
# Auxiliary Channel Transaction Retry Sequencer

This block runs one request/reply exchange on a display auxiliary channel for a host. The host presents a command code, a target address, a byte count and up to sixteen data bytes with a one-cycle `reqValid` strobe. The sequencer first checks the request. It rejects an oversize or zero count and any command that belongs to neither the read set nor the write set. It also refuses a read when no sink is plugged. After these checks it launches the exchange on a simple start/done/status channel interface.

After each launch the sequencer samples completion at a fixed poll interval, within an overall time budget. It then inspects the reply status. Link-level error flags and defer replies each draw on their own retry budget. Before every relaunch the sequencer clears the sticky status and waits a pause, which is shorter for writes than for reads. An acknowledge ends the exchange. The block then returns the byte count the sink reported and, for reads, that many bytes of read data. A one-cycle done pulse marks the result, together with a two-bit code.

Top module: `auxRetrySeq`

## Requirements
- R1: Command codes 4'h0 (I2C write), 4'h4 (I2C write, transaction kept open) and 4'h8 (native write) are writes. Codes 4'h1 (I2C read), 4'h2 (I2C status request), 4'h5 (I2C read, transaction kept open) and 4'h9 (native read) are reads. Any other code finishes with result 2'b01 and no channel launch.
- R2: A byte count of 0 or above 16 finishes with result 2'b01 and no launch. An accepted count is presented on `chLenM1` as count minus one.
- R3: A read finishes with result 2'b11 and no launch when `hpdPlugged` is low at the check. A write does not depend on `hpdPlugged`.
- R4: Any set bit of `chErrFlags` (timeout, receive error, sink status error, missing stop) causes one `chClear` pulse and a relaunch, up to ERR_RETRIES relaunches. The next such reply finishes with result 2'b10.
- R5: A native defer (`chReply`=2'b10) or I2C defer (2'b11) relaunches in the same way under a separate DEFER_RETRIES budget, which is independent of the R4 budget. Exhausting it gives result 2'b10.
- R6: An acknowledge (`chReply`=2'b00) with no error flag finishes with result 2'b00 and `rspCount` equal to `chReplyCount`. For reads, `rspData` holds bytes below that count, taken from `chRdData` with byte i at bits 8i+7:8i. All other bytes, and all bytes of a write, are zero.
- R7: A reply of 2'b01 (not acknowledged) with no error flag finishes with result 2'b11.
- R8: The first launch follows the request strobe by two cycles, with no pause. Each relaunch follows its `chClear` by the write pause or read pause plus one cycle.
- R9: Completion is sampled every poll interval. If `chDone` has not been seen after the full number of polls, the status is examined anyway.
- R10: `rspDone` is a single-cycle pulse and `busy` is high from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqCmd | input | 4 | Command code |
| reqAddr | input | ADDR_W | Target address |
| reqLen | input | LEN_W | Requested byte count |
| reqData | input | DATA_W | Write data, byte 0 in the low bits |
| hpdPlugged | input | 1 | Sink-present status |
| chStart | output | 1 | Launch pulse to the channel engine |
| chClear | output | 1 | Clear pulse for the sticky channel status |
| chCmd | output | 4 | Command to the channel engine |
| chAddr | output | ADDR_W | Address to the channel engine |
| chLenM1 | output | LENF_W | Byte count minus one |
| chWrData | output | DATA_W | Write data to the channel engine |
| chDone | input | 1 | Channel transaction complete |
| chErrFlags | input | 4 | Timeout, receive, sink status, missing-stop error flags |
| chReply | input | 2 | Reply type: ack, nack, defer, I2C defer |
| chReplyCount | input | LENF_W+1 | Byte count reported in the reply |
| chRdData | input | DATA_W | Read data from the channel engine |
| busy | output | 1 | Exchange in progress |
| rspDone | output | 1 | Result valid pulse |
| rspCode | output | 2 | Result: ok, bad request, timeout, failure |
| rspCount | output | LENF_W+1 | Transferred byte count |
| rspData | output | DATA_W | Read data |

## Verification
The retry budgets and the poll counter are never visible directly. A corrupted budget shows up as the wrong number of `chStart` and `chClear` pulses, or as a timeout result that arrives one relaunch early or late; both are observable by the end of the exchange. A wrong poll or pause counter moves the launch-to-done and clear-to-relaunch distances. Those distances are measured exactly, so the error appears at the first retry or the first completed exchange. A wrong decode flag shows up as a launch for a request that should have been rejected. That launch, or its absence, is visible two cycles after the strobe.

// File: rtl/auxRetryPkg.sv
package auxRetryPkg;

  localparam logic [3:0] CMD_I2C_WR     = 4'h0;
  localparam logic [3:0] CMD_I2C_RD     = 4'h1;
  localparam logic [3:0] CMD_I2C_STAT   = 4'h2;
  localparam logic [3:0] CMD_I2C_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_I2C_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR     = 4'h8;
  localparam logic [3:0] CMD_NAT_RD     = 4'h9;

  localparam logic [1:0] REP_ACK       = 2'b00;
  localparam logic [1:0] REP_NACK      = 2'b01;
  localparam logic [1:0] REP_DEFER     = 2'b10;
  localparam logic [1:0] REP_I2C_DEFER = 2'b11;

  localparam logic [1:0] RES_OK      = 2'b00;
  localparam logic [1:0] RES_BADREQ  = 2'b01;
  localparam logic [1:0] RES_TIMEOUT = 2'b10;
  localparam logic [1:0] RES_FAIL    = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_LAUNCH, S_WAIT, S_EVAL, S_PAUSE, S_RESP
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic loadBudgets;
    logic clrTmr;
    logic clrPoll;
    logic countPoll;
    logic decErr;
    logic decDefer;
    logic capture;
  } seqStrobe_t;

endpackage

// File: rtl/auxSeqData.sv
module auxSeqData
  import auxRetryPkg::*;
#(
  parameter int MAX_BYTES     = 16,
  parameter int ADDR_W        = 20,
  parameter int ERR_RETRIES   = 7,
  parameter int DEFER_RETRIES = 7,
  parameter int POLL_CYC      = 12500,
  parameter int MAX_POLLS     = 400,
  parameter int WR_PAUSE      = 125,
  parameter int RD_PAUSE      = 2500,
  localparam int DATA_W  = MAX_BYTES * 8,
  localparam int LENF_W  = $clog2(MAX_BYTES),
  localparam int LEN_W   = LENF_W + 2,
  localparam int CNT_W   = LENF_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         str,
  input  logic [3:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [CNT_W-1:0]   chReplyCount,
  input  logic [DATA_W-1:0]  chRdData,
  output logic               cmdLegal,
  output logic               isRead,
  output logic               lenOk,
  output logic               pollTick,
  output logic               pollExpired,
  output logic               pauseDone,
  output logic               errSpent,
  output logic               deferSpent,
  output logic [3:0]         chCmd,
  output logic [ADDR_W-1:0]  chAddr,
  output logic [LENF_W-1:0]  chLenM1,
  output logic [DATA_W-1:0]  chWrData,
  output logic [CNT_W-1:0]   rspCount,
  output logic [DATA_W-1:0]  rspData
);

  localparam int TMR_MAX = (POLL_CYC > RD_PAUSE)
                           ? ((POLL_CYC > WR_PAUSE) ? POLL_CYC : WR_PAUSE)
                           : ((RD_PAUSE > WR_PAUSE) ? RD_PAUSE : WR_PAUSE);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);
  localparam int ERR_W   = $clog2(ERR_RETRIES + 1);
  localparam int DEF_W   = $clog2(DEFER_RETRIES + 1);

  logic [3:0]        cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] dataReg;
  logic [TMR_W-1:0]  tmr;
  logic [POLL_W-1:0] pollCnt;
  logic [ERR_W-1:0]  errLeft;
  logic [DEF_W-1:0]  deferLeft;
  logic              isWrite;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      lenReg  <= '0;
      dataReg <= '0;
    end else if (str.latchReq) begin
      cmdReg  <= reqCmd;
      addrReg <= reqAddr;
      lenReg  <= reqLen;
      dataReg <= reqData;
    end
  end

  // Direction decode
  always_comb begin
    isRead  = 1'b0;
    isWrite = 1'b0;
    unique case (cmdReg)
      CMD_I2C_RD, CMD_I2C_STAT, CMD_I2C_MOT_RD, CMD_NAT_RD: isRead  = 1'b1;
      CMD_I2C_WR, CMD_I2C_MOT_WR, CMD_NAT_WR:               isWrite = 1'b1;
      default: ;
    endcase
  end

  assign cmdLegal = isRead | isWrite;
  assign lenOk    = (lenReg != '0) && (lenReg <= LEN_W'(MAX_BYTES));

  assign chCmd    = cmdReg;
  assign chAddr   = addrReg;
  assign chLenM1  = LENF_W'(lenReg - 1'b1);
  assign chWrData = dataReg;

  // Shared poll / pause timer
  always_ff @(posedge clk) begin
    if (!rstN || str.clrTmr) tmr <= '0;
    else if (tmr != TMR_W'(TMR_MAX)) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || str.clrPoll) pollCnt <= '0;
    else if (str.countPoll) pollCnt <= pollCnt + 1'b1;
  end

  assign pollTick    = (tmr == TMR_W'(POLL_CYC - 1));
  assign pollExpired = (pollCnt == POLL_W'(MAX_POLLS - 1));

  // Pause length picked per direction
  generate
    if (RD_PAUSE == WR_PAUSE) begin : gSamePause
      assign pauseDone = (tmr == TMR_W'(WR_PAUSE - 1));
    end else begin : gSplitPause
      assign pauseDone = isRead ? (tmr == TMR_W'(RD_PAUSE - 1))
                                : (tmr == TMR_W'(WR_PAUSE - 1));
    end
  endgenerate

  // Two independent retry budgets
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errLeft   <= '0;
      deferLeft <= '0;
    end else if (str.loadBudgets) begin
      errLeft   <= ERR_W'(ERR_RETRIES);
      deferLeft <= DEF_W'(DEFER_RETRIES);
    end else begin
      if (str.decErr)   errLeft   <= errLeft - 1'b1;
      if (str.decDefer) deferLeft <= deferLeft - 1'b1;
    end
  end

  assign errSpent   = (errLeft == '0);
  assign deferSpent = (deferLeft == '0);

  // Response capture: only bytes below the reply count, and only for reads
  always_ff @(posedge clk) begin
    if (!rstN || str.latchReq) rspCount <= '0;
    else if (str.capture) rspCount <= chReplyCount;
  end

  genvar gi;
  generate
    for (gi = 0; gi < MAX_BYTES; gi++) begin : gByte
      always_ff @(posedge clk) begin
        if (!rstN || str.latchReq)
          rspData[gi*8 +: 8] <= '0;
        else if (str.capture && isRead && (CNT_W'(gi) < chReplyCount))
          rspData[gi*8 +: 8] <= chRdData[gi*8 +: 8];
      end
    end
  endgenerate

  // R4: the error budget only falls between loads
  assert_err_budget_R4: assert property (@(posedge clk) disable iff (!rstN)
    !str.loadBudgets |=> (errLeft <= $past(errLeft)));

  // R5: the defer budget is never drawn below zero
  assert_defer_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.decDefer |-> (deferLeft != '0));

endmodule

// File: rtl/auxSeqCtrl.sv
module auxSeqCtrl
  import auxRetryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hpdPlugged,
  input  logic       chDone,
  input  logic [3:0] chErrFlags,
  input  logic [1:0] chReply,
  input  logic       cmdLegal,
  input  logic       isRead,
  input  logic       lenOk,
  input  logic       pollTick,
  input  logic       pollExpired,
  input  logic       pauseDone,
  input  logic       errSpent,
  input  logic       deferSpent,
  output seqStrobe_t str,
  output logic       chStart,
  output logic       chClear,
  output logic       busy,
  output logic       rspDone,
  output logic [1:0] rspCode
);

  seqState_t state, stateNxt;
  logic [1:0] codeNxt;
  logic       codeLoad;
  logic       hasErr, isDefer;

  assign hasErr  = |chErrFlags;
  assign isDefer = (chReply == REP_DEFER) || (chReply == REP_I2C_DEFER);

  always_comb begin
    stateNxt = state;
    str      = '0;
    chStart  = 1'b0;
    chClear  = 1'b0;
    codeLoad = 1'b0;
    codeNxt  = RES_OK;
    unique case (state)
      S_IDLE: if (reqValid) begin
        str.latchReq    = 1'b1;
        str.loadBudgets = 1'b1;
        stateNxt        = S_CHECK;
      end
      S_CHECK: begin
        if (!lenOk || !cmdLegal) begin
          codeLoad = 1'b1;
          codeNxt  = RES_BADREQ;
          stateNxt = S_RESP;
        end else if (isRead && !hpdPlugged) begin
          codeLoad = 1'b1;
          codeNxt  = RES_FAIL;
          stateNxt = S_RESP;
        end else begin
          stateNxt = S_LAUNCH;
        end
      end
      S_LAUNCH: begin
        chStart     = 1'b1;
        str.clrTmr  = 1'b1;
        str.clrPoll = 1'b1;
        stateNxt    = S_WAIT;
      end
      S_WAIT: if (pollTick) begin
        str.clrTmr    = 1'b1;
        str.countPoll = 1'b1;
        if (chDone || pollExpired) stateNxt = S_EVAL;
      end
      S_EVAL: begin
        if (hasErr) begin
          if (errSpent) begin
            codeLoad = 1'b1;
            codeNxt  = RES_TIMEOUT;
            stateNxt = S_RESP;
          end else begin
            str.decErr = 1'b1;
            str.clrTmr = 1'b1;
            chClear    = 1'b1;
            stateNxt   = S_PAUSE;
          end
        end else if (isDefer) begin
          if (deferSpent) begin
            codeLoad = 1'b1;
            codeNxt  = RES_TIMEOUT;
            stateNxt = S_RESP;
          end else begin
            str.decDefer = 1'b1;
            str.clrTmr   = 1'b1;
            chClear      = 1'b1;
            stateNxt     = S_PAUSE;
          end
        end else if (chReply == REP_ACK) begin
          str.capture = 1'b1;
          codeLoad    = 1'b1;
          codeNxt     = RES_OK;
          stateNxt    = S_RESP;
        end else begin
          codeLoad = 1'b1;
          codeNxt  = RES_FAIL;
          stateNxt = S_RESP;
        end
      end
      S_PAUSE: if (pauseDone) stateNxt = S_LAUNCH;
      S_RESP:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rspCode <= RES_OK;
    end else begin
      state <= stateNxt;
      if (codeLoad) rspCode <= codeNxt;
    end
  end

  assign busy    = (state != S_IDLE);
  assign rspDone = (state == S_RESP);

  // R10: the result strobe lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R1 / R2: a launch only ever follows a legal, in-range request
  assert_launch_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    chStart |-> (cmdLegal && lenOk));

  // R3: an unplugged read at the check goes straight to the result
  assert_unplugged_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && cmdLegal && lenOk && isRead && !hpdPlugged) |=> (rspDone && rspCode == RES_FAIL));

  // R4: an error reply with budget left always leads into a pause
  assert_err_retry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EVAL && hasErr && !errSpent) |=> (state == S_PAUSE));

endmodule

// File: rtl/auxRetrySeq.sv
module auxRetrySeq
  import auxRetryPkg::*;
#(
  parameter int MAX_BYTES     = 16,
  parameter int ADDR_W        = 20,
  parameter int ERR_RETRIES   = 7,
  parameter int DEFER_RETRIES = 7,
  parameter int CLK_KHZ       = 125000,
  parameter int POLL_US       = 100,
  parameter int TIMEOUT_US    = 40000,
  parameter int WR_PAUSE_US   = 1,
  parameter int RD_PAUSE_US   = 20,
  localparam int DATA_W    = MAX_BYTES * 8,
  localparam int LENF_W    = $clog2(MAX_BYTES),
  localparam int LEN_W     = LENF_W + 2,
  localparam int CNT_W     = LENF_W + 1,
  localparam int POLL_RAW  = CLK_KHZ * POLL_US / 1000,
  localparam int WR_RAW    = CLK_KHZ * WR_PAUSE_US / 1000,
  localparam int RD_RAW    = CLK_KHZ * RD_PAUSE_US / 1000,
  localparam int POLL_CYC  = (POLL_RAW < 1) ? 1 : POLL_RAW,
  localparam int WR_PAUSE  = (WR_RAW < 1) ? 1 : WR_RAW,
  localparam int RD_PAUSE  = (RD_RAW < 1) ? 1 : RD_RAW,
  localparam int MAX_POLLS = (TIMEOUT_US / POLL_US < 1) ? 1 : TIMEOUT_US / POLL_US
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [3:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               hpdPlugged,
  output logic               chStart,
  output logic               chClear,
  output logic [3:0]         chCmd,
  output logic [ADDR_W-1:0]  chAddr,
  output logic [LENF_W-1:0]  chLenM1,
  output logic [DATA_W-1:0]  chWrData,
  input  logic               chDone,
  input  logic [3:0]         chErrFlags,
  input  logic [1:0]         chReply,
  input  logic [CNT_W-1:0]   chReplyCount,
  input  logic [DATA_W-1:0]  chRdData,
  output logic               busy,
  output logic               rspDone,
  output logic [1:0]         rspCode,
  output logic [CNT_W-1:0]   rspCount,
  output logic [DATA_W-1:0]  rspData
);

  seqStrobe_t str;
  logic cmdLegal, isRead, lenOk, pollTick, pollExpired, pauseDone;
  logic errSpent, deferSpent;

  auxSeqCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .hpdPlugged  (hpdPlugged),
    .chDone      (chDone),
    .chErrFlags  (chErrFlags),
    .chReply     (chReply),
    .cmdLegal    (cmdLegal),
    .isRead      (isRead),
    .lenOk       (lenOk),
    .pollTick    (pollTick),
    .pollExpired (pollExpired),
    .pauseDone   (pauseDone),
    .errSpent    (errSpent),
    .deferSpent  (deferSpent),
    .str         (str),
    .chStart     (chStart),
    .chClear     (chClear),
    .busy        (busy),
    .rspDone     (rspDone),
    .rspCode     (rspCode)
  );

  auxSeqData #(
    .MAX_BYTES     (MAX_BYTES),
    .ADDR_W        (ADDR_W),
    .ERR_RETRIES   (ERR_RETRIES),
    .DEFER_RETRIES (DEFER_RETRIES),
    .POLL_CYC      (POLL_CYC),
    .MAX_POLLS     (MAX_POLLS),
    .WR_PAUSE      (WR_PAUSE),
    .RD_PAUSE      (RD_PAUSE)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .str          (str),
    .reqCmd       (reqCmd),
    .reqAddr      (reqAddr),
    .reqLen       (reqLen),
    .reqData      (reqData),
    .chReplyCount (chReplyCount),
    .chRdData     (chRdData),
    .cmdLegal     (cmdLegal),
    .isRead       (isRead),
    .lenOk        (lenOk),
    .pollTick     (pollTick),
    .pollExpired  (pollExpired),
    .pauseDone    (pauseDone),
    .errSpent     (errSpent),
    .deferSpent   (deferSpent),
    .chCmd        (chCmd),
    .chAddr       (chAddr),
    .chLenM1      (chLenM1),
    .chWrData     (chWrData),
    .rspCount     (rspCount),
    .rspData      (rspData)
  );

endmodule

// File: tb/auxRetrySeq_tb.sv
`timescale 1ns/1ps
module auxRetrySeq_tb;

  localparam int CLK_KHZ = 200;      // scaled timing so the bench stays short
  localparam int POLL    = 20;       // 100 us at the scaled clock
  localparam int MAXP    = 400;      // 40 ms / 100 us
  localparam int WRP     = 1;
  localparam int RDP     = 4;
  localparam int BUDGET  = 7;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [3:0]   reqCmd = '0;
  logic [19:0]  reqAddr = '0;
  logic [5:0]   reqLen = '0;
  logic [127:0] reqData = '0;
  logic         hpdPlugged = 1'b1;
  logic         chStart, chClear;
  logic [3:0]   chCmd;
  logic [19:0]  chAddr;
  logic [3:0]   chLenM1;
  logic [127:0] chWrData;
  logic         chDone = 1'b0;
  logic [3:0]   chErrFlags = '0;
  logic [1:0]   chReply = '0;
  logic [4:0]   chReplyCount = '0;
  logic [127:0] chRdData = '0;
  logic         busy, rspDone;
  logic [1:0]   rspCode;
  logic [4:0]   rspCount;
  logic [127:0] rspData;

  always #4 clk = ~clk;

  auxRetrySeq #(.CLK_KHZ(CLK_KHZ)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqData(reqData),
    .hpdPlugged(hpdPlugged), .chStart(chStart), .chClear(chClear),
    .chCmd(chCmd), .chAddr(chAddr), .chLenM1(chLenM1), .chWrData(chWrData),
    .chDone(chDone), .chErrFlags(chErrFlags), .chReply(chReply),
    .chReplyCount(chReplyCount), .chRdData(chRdData), .busy(busy),
    .rspDone(rspDone), .rspCode(rspCode), .rspCount(rspCount), .rspData(rspData)
  );

  // Reply script: 0 ack, 1 nack, 2 link error, 3 native defer, 4 I2C defer
  int          scKind [0:31];
  logic [4:0]  scM    [0:31];
  int          scLat;
  logic [127:0] sinkData;

  int checks = 0, fails = 0;
  int cyc = 0, reqCyc = 0, firstStartCyc = 0, clrCyc = 0;
  int nStarts = 0, nClears = 0, attIdx = 0, dly = 0, expPause = 1;
  bit gapArmed = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit isRd(input logic [3:0] c);
    return c == 4'h1 || c == 4'h2 || c == 4'h5 || c == 4'h9;
  endfunction
  function automatic bit isWr(input logic [3:0] c);
    return c == 4'h0 || c == 4'h4 || c == 4'h8;
  endfunction

  // Expected result and number of launches from the requirements
  function automatic void model(input logic [3:0] c, input int len, input bit hpd,
                                output int code, output int att);
    int e = 0, d = 0;
    att = 0;
    if (len < 1 || len > 16 || !(isRd(c) || isWr(c))) begin code = 1; return; end
    if (isRd(c) && !hpd) begin code = 3; return; end
    for (int i = 0; i < 32; i++) begin
      att = i + 1;
      if (scKind[i] == 2) begin
        if (e == BUDGET) begin code = 2; return; end
        e++;
      end else if (scKind[i] == 3 || scKind[i] == 4) begin
        if (d == BUDGET) begin code = 2; return; end
        d++;
      end else begin
        code = (scKind[i] == 0) ? 0 : 3;
        return;
      end
    end
    code = 2;
  endfunction

  // Channel engine model, also measures launch spacing
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (reqValid) reqCyc = cyc;
      if (chStart) begin
        nStarts++;
        if (nStarts == 1) begin
          firstStartCyc = cyc;
          check(cyc - reqCyc == 2, "R8 first launch without pause", cyc - reqCyc, 2);
        end
        if (gapArmed)
          check(cyc - clrCyc == expPause + 1, "R8 pause before relaunch", cyc - clrCyc, expPause + 1);
        gapArmed = 0;
        if (chLenM1 != 4'(reqLen - 1) || chCmd != reqCmd || chAddr != reqAddr || chWrData != reqData)
          check(0, "R2 launch fields", {chCmd, chAddr, chLenM1}, {reqCmd, reqAddr, 4'(reqLen - 1)});
        chErrFlags   = '0;
        chReply      = 2'b00;
        chReplyCount = scM[attIdx];
        chRdData     = sinkData;
        case (scKind[attIdx])
          1: chReply = 2'b01;
          2: begin chErrFlags = 4'(1 << ($urandom % 4)); chReply = 2'($urandom); end
          3: chReply = 2'b10;
          4: chReply = 2'b11;
          default: ;
        endcase
        if (attIdx < 31) attIdx++;
        chDone = 1'b0;
        dly    = scLat;
      end else if (dly > 0) begin
        dly--;
        if (dly == 0) chDone = 1'b1;
      end
      if (chClear) begin
        nClears++;
        clrCyc   = cyc;
        gapArmed = 1;
      end
    end
  end

  task automatic runTxn(input logic [3:0] c, input int len, input bit hpd, input string tag,
                        input int expElapsed);
    int code, att, doneCyc, waitCnt;
    logic [127:0] expData;
    model(c, len, hpd, code, att);
    expPause = isRd(c) ? RDP : WRP;
    @(posedge clk); #1;
    nStarts = 0; nClears = 0; attIdx = 0; gapArmed = 0;
    reqCmd = c; reqLen = 6'(len); reqAddr = 20'($urandom);
    reqData = {$urandom, $urandom, $urandom, $urandom};
    sinkData = {$urandom, $urandom, $urandom, $urandom};
    hpdPlugged = hpd;
    reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    waitCnt = 0;
    do begin
      @(negedge clk);
      waitCnt++;
    end while (!rspDone && waitCnt < 20000);
    doneCyc = cyc;
    check(rspDone, {tag, " R10 done seen"}, rspDone, 1);
    check(rspCode == 2'(code), {tag, " result code"}, rspCode, code);
    check(nStarts == att, {tag, " R4 R5 launch count"}, nStarts, att);
    check(nClears == ((att > 0) ? att - 1 : 0), {tag, " R4 R5 clear count"}, nClears, (att > 0) ? att - 1 : 0);
    if (code == 0) begin
      check(rspCount == scM[att - 1], {tag, " R6 count"}, rspCount, scM[att - 1]);
      expData = '0;
      if (isRd(c))
        for (int b = 0; b < 16; b++)
          if (b < scM[att - 1]) expData[b*8 +: 8] = sinkData[b*8 +: 8];
      check(rspData == expData, {tag, " R6 data"}, rspData, expData);
    end
    if (expElapsed > 0)
      check(doneCyc - firstStartCyc == expElapsed, {tag, " R9 poll timing"}, doneCyc - firstStartCyc, expElapsed);
    @(negedge clk);
    check(!rspDone && !busy, {tag, " R10 single pulse"}, {rspDone, busy}, 0);
  endtask

  task automatic fillAck(input logic [4:0] m);
    for (int i = 0; i < 32; i++) begin scKind[i] = 0; scM[i] = m; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    scLat = 3;
    fillAck(5'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !rspDone && !chStart && !chClear, "R10 reset state", {busy, rspDone, chStart, chClear}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    // R6: ack paths, write and partial read
    fillAck(5'd4);  runTxn(4'h8, 4, 1, "R6 native write", 0);
    fillAck(5'd10); runTxn(4'h9, 16, 1, "R6 native read partial", 0);
    // R9: exact poll interval with early completion
    scLat = 5; fillAck(5'd2); runTxn(4'h1, 2, 1, "R9 one poll", POLL + 2);
    // R2: length limits
    runTxn(4'h8, 17, 1, "R2 oversize", 0);
    runTxn(4'h9, 0, 1, "R2 zero length", 0);
    fillAck(5'd1); runTxn(4'h5, 1, 1, "R2 single byte", 0);
    // R1: illegal commands, all legal codes
    runTxn(4'h3, 4, 1, "R1 illegal 3", 0);
    runTxn(4'hF, 4, 1, "R1 illegal F", 0);
    fillAck(5'd3); runTxn(4'h0, 3, 1, "R1 i2c write", 0);
    fillAck(5'd3); runTxn(4'h2, 3, 1, "R1 status request", 0);
    // R3: hot-plug gate
    runTxn(4'h9, 4, 0, "R3 unplugged read", 0);
    fillAck(5'd4); runTxn(4'h4, 4, 0, "R3 unplugged write", 0);
    // R4: error budget
    fillAck(5'd6); for (int i = 0; i < 7; i++) scKind[i] = 2;
    runTxn(4'h9, 6, 1, "R4 seven errors", 0);
    fillAck(5'd6); for (int i = 0; i < 8; i++) scKind[i] = 2;
    runTxn(4'h8, 6, 1, "R4 error exhaust", 0);
    // R5: defer budget and independence from the error budget
    fillAck(5'd2); for (int i = 0; i < 8; i++) scKind[i] = (i % 2) ? 3 : 4;
    runTxn(4'h1, 2, 1, "R5 defer exhaust", 0);
    fillAck(5'd8); for (int i = 0; i < 14; i++) scKind[i] = (i % 2) ? 2 : 3;
    runTxn(4'h9, 8, 1, "R5 independent budgets", 0);
    // R7: not acknowledged
    fillAck(5'd0); scKind[0] = 1; runTxn(4'h8, 2, 1, "R7 nack", 0);
    fillAck(5'd0); scKind[0] = 3; scKind[1] = 1; runTxn(4'h9, 2, 1, "R7 nack after defer", 0);
    // R9: no completion at all, status still examined
    scLat = 0; fillAck(5'd3); runTxn(4'h9, 3, 1, "R9 poll budget spent", MAXP * POLL + 2);

    // Random mix
    for (int t = 0; t < 40; t++) begin
      logic [3:0] c;
      int len, r;
      logic [4:0] m;
      c   = 4'($urandom % 16);
      if ($urandom % 4 != 0) c = ($urandom % 2) ? 4'(($urandom % 2) ? 9 : 1) : 4'(($urandom % 2) ? 8 : 4);
      len = 1 + ($urandom % 18);
      m   = 5'((len > 16) ? 0 : ($urandom % (len + 1)));
      scLat = 1 + ($urandom % 60);
      for (int i = 0; i < 32; i++) begin
        r = $urandom % 10;
        scKind[i] = (r < 5) ? 0 : (r == 5) ? 1 : (r < 8) ? 2 : (r == 8) ? 3 : 4;
        scM[i] = m;
      end
      runTxn(c, len, ($urandom % 8) != 0, "random", 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule